// File: doc/BRIEF.md
# Stereo DC Offset Removal Filter

This block sits behind a decimator and runs at the output sample rate. It receives one left and one right 24-bit two's-complement sample on each strobe. For each channel it keeps a running estimate of the DC level as a leaky integrator. It subtracts the whole-LSB part of that estimate from the incoming sample and saturates the difference to 24 bits. The result is a first-order high-pass response. With a shift of 13, the -3 dB corner is close to 0.93 Hz at a 48 kHz sample rate, and the corner moves in proportion to the rate. The estimate settles within roughly 10^5 samples.

A freeze input stops both estimates from changing, but the held values are still subtracted from every sample. A system can therefore run with the filter tracking until it settles, then assert freeze and keep that fixed offset as a one-time calibration. Both channels are processed in the same clock cycle and do not interact. The results leave the block through a register, one clock after each strobe.

Top module: `dcrm_filter`

## Requirements
- R1: Synchronous active-high reset clears both estimator accumulators and both output registers to zero and drives `out_vld` low. The first sample after reset therefore passes through unchanged.
- R2: `out_vld` is high in the cycle after every cycle in which `in_vld` is high, and low after every cycle in which it is low.
- R3: On a strobe, each output becomes sat(x - floor(A / 2^13)). Here x is the channel's input and A is that channel's accumulator before this sample. A is a signed value with 13 fractional bits.
- R4: On a strobe with `freeze` low, each accumulator becomes A + floor((x * 2^13 - A) / 2^13).
- R5: On a strobe with `freeze` high, both accumulators keep their values, and the held estimate is still subtracted as in R3.
- R6: The subtraction result is limited to the range -8388608 to 8388607 and never wraps. A non-negative input with a negative estimate gives a non-negative output. A negative input with a non-negative estimate gives a negative output.
- R7: The left and right estimators are independent. A channel's output depends only on that channel's own input history.
- R8: While `in_vld` is low, `out_left` and `out_right` keep their last values.
- R9: When `freeze` is deasserted, updating resumes from the held accumulator value and not from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_vld | input | 1 | Sample strobe for both channels |
| freeze | input | 1 | Hold the offset estimates; the held values are still subtracted |
| in_left | input | 24 | Left input sample, two's complement |
| in_right | input | 24 | Right input sample, two's complement |
| out_vld | output | 1 | Result valid, one clock after `in_vld` |
| out_left | output | 24 | Left filtered sample |
| out_right | output | 24 | Right filtered sample |

## Verification
A corrupted accumulator shows up on the very next strobe as a wrong output. It is never masked, because every output subtracts the current estimate directly. Because the estimate moves by only 1/8192 of the error on each sample, a wrong update step can hide for a few samples. It then grows into a clear output difference within a few hundred samples of steady input, so the bench compares every sample against a bit-exact model. A freeze leak is visible only as output drift under constant input, which the frozen phase exposes. A saturation wrap shows up at once as a sign flip at full-scale input.

// File: rtl/dcrm_pkg.sv
package dcrm_pkg;
  localparam int unsigned DEF_DATA_W = 24;
  localparam int unsigned DEF_SHIFT  = 13;
  localparam int unsigned NUM_CH     = 2;

  typedef enum logic {
    EST_TRACK = 1'b0,
    EST_HOLD  = 1'b1
  } est_mode_e;
endpackage

// File: rtl/dcrm_sat.sv
module dcrm_sat #(
  parameter int unsigned IN_W  = 25,
  parameter int unsigned OUT_W = 24
) (
  input  logic signed [IN_W-1:0]  din,
  output logic signed [OUT_W-1:0] dout
);
  localparam int unsigned EXT_W = IN_W - OUT_W + 1;
  localparam logic signed [IN_W-1:0] MAXV = {{EXT_W{1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] MINV = {{EXT_W{1'b1}}, {(OUT_W-1){1'b0}}};
  localparam logic signed [OUT_W-1:0] OMAX = {1'b0, {(OUT_W-1){1'b1}}};
  localparam logic signed [OUT_W-1:0] OMIN = {1'b1, {(OUT_W-1){1'b0}}};

  always_comb begin
    if (din > MAXV)      dout = OMAX;
    else if (din < MINV) dout = OMIN;
    else                 dout = din[OUT_W-1:0];
  end
endmodule

// File: rtl/dcrm_chan.sv
module dcrm_chan
  import dcrm_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SHIFT  = DEF_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_vld,
  input  logic                     hold,
  input  logic signed [DATA_W-1:0] smp_in,
  output logic signed [DATA_W-1:0] res_out,
  output logic signed [DATA_W-1:0] est_out
);
  localparam int unsigned ACC_W = DATA_W + SHIFT;
  localparam int unsigned DIF_W = ACC_W + 1;
  localparam int unsigned SUB_W = DATA_W + 1;

  est_mode_e                 mode;
  logic signed [ACC_W-1:0]   acc_q;
  logic signed [ACC_W-1:0]   acc_nxt;
  logic signed [DIF_W-1:0]   x_scaled;
  logic signed [DIF_W-1:0]   err;
  logic signed [DIF_W-1:0]   step;
  logic signed [DIF_W-1:0]   acc_sum;
  logic signed [DATA_W-1:0]  est;
  logic signed [SUB_W-1:0]   diff;
  logic signed [DATA_W-1:0]  diff_sat;

  assign mode = hold ? EST_HOLD : EST_TRACK;

  // whole-LSB part of the estimate; dropping fraction bits floors it
  assign est = acc_q[ACC_W-1:SHIFT];

  assign x_scaled = {smp_in[DATA_W-1], smp_in, {SHIFT{1'b0}}};
  assign err      = x_scaled - {acc_q[ACC_W-1], acc_q};
  assign step     = err >>> SHIFT;
  assign acc_sum  = {acc_q[ACC_W-1], acc_q} + step;
  assign acc_nxt  = acc_sum[ACC_W-1:0];

  assign diff = {smp_in[DATA_W-1], smp_in} - {est[DATA_W-1], est};

  dcrm_sat #(.IN_W(SUB_W), .OUT_W(DATA_W)) sat_i (
    .din  (diff),
    .dout (diff_sat)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q   <= '0;
      res_out <= '0;
    end else if (smp_vld) begin
      res_out <= diff_sat;
      if (mode == EST_TRACK) acc_q <= acc_nxt;
    end
  end

  assign est_out = est;
endmodule

// File: rtl/dcrm_filter.sv
module dcrm_filter
  import dcrm_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned SHIFT  = DEF_SHIFT
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     in_vld,
  input  logic                     freeze,
  input  logic signed [DATA_W-1:0] in_left,
  input  logic signed [DATA_W-1:0] in_right,
  output logic                     out_vld,
  output logic signed [DATA_W-1:0] out_left,
  output logic signed [DATA_W-1:0] out_right
);
  logic signed [DATA_W-1:0] ch_in  [NUM_CH];
  logic signed [DATA_W-1:0] ch_out [NUM_CH];
  logic signed [DATA_W-1:0] ch_est [NUM_CH];
  logic signed [DATA_W-1:0] est_left;
  logic signed [DATA_W-1:0] est_right;

  assign ch_in[0] = in_left;
  assign ch_in[1] = in_right;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    dcrm_chan #(.DATA_W(DATA_W), .SHIFT(SHIFT)) chan_i (
      .clk     (clk),
      .rst     (rst),
      .smp_vld (in_vld),
      .hold    (freeze),
      .smp_in  (ch_in[c]),
      .res_out (ch_out[c]),
      .est_out (ch_est[c])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) out_vld <= 1'b0;
    else     out_vld <= in_vld;
  end

  assign out_left  = ch_out[0];
  assign out_right = ch_out[1];
  assign est_left  = ch_est[0];
  assign est_right = ch_est[1];
endmodule

// File: rtl/dcrm_filter_chk.sv
module dcrm_filter_chk #(
  parameter int unsigned DATA_W = 24
) (
  input logic                     clk,
  input logic                     rst,
  input logic                     in_vld,
  input logic                     freeze,
  input logic signed [DATA_W-1:0] in_left,
  input logic signed [DATA_W-1:0] in_right,
  input logic                     out_vld,
  input logic signed [DATA_W-1:0] out_left,
  input logic signed [DATA_W-1:0] out_right,
  input logic signed [DATA_W-1:0] est_left,
  input logic signed [DATA_W-1:0] est_right
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_vld && out_left == '0 && out_right == '0)); // R1

  AST_VLD_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_vld |=> out_vld); // R2

  AST_NO_SPURIOUS_VLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> !out_vld); // R2

  AST_FREEZE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (in_vld && freeze) |=> ($stable(est_left) && $stable(est_right))); // R5

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_vld && !in_left[DATA_W-1] && est_left[DATA_W-1]) |=> !out_left[DATA_W-1]); // R6

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (in_vld && in_right[DATA_W-1] && !est_right[DATA_W-1]) |=> out_right[DATA_W-1]); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_vld |=> ($stable(out_left) && $stable(out_right))); // R8
endmodule

bind dcrm_filter dcrm_filter_chk #(.DATA_W(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_vld    (in_vld),
  .freeze    (freeze),
  .in_left   (in_left),
  .in_right  (in_right),
  .out_vld   (out_vld),
  .out_left  (out_left),
  .out_right (out_right),
  .est_left  (est_left),
  .est_right (est_right)
);

// File: tb/dcrm_filter_tb_top.sv
module dcrm_filter_tb_top;
  localparam int W  = 24;
  localparam int SH = 13;
  localparam longint MAXV = 64'sd8388607;
  localparam longint MINV = -64'sd8388608;

  typedef struct {
    longint l;
    longint r;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_vld = 1'b0;
  logic freeze = 1'b0;
  logic signed [W-1:0] in_left = '0;
  logic signed [W-1:0] in_right = '0;
  logic out_vld;
  logic signed [W-1:0] out_left;
  logic signed [W-1:0] out_right;

  int n_chk = 0;
  int n_fail = 0;
  int n_sent = 0;
  int n_recv = 0;
  longint acc_m[2];
  longint last_l = 0;
  longint last_r = 0;
  exp_t sb[$];
  bit monitor_on = 1'b0;

  always #10 clk = ~clk;

  dcrm_filter dut_i (
    .clk(clk), .rst(rst), .in_vld(in_vld), .freeze(freeze),
    .in_left(in_left), .in_right(in_right),
    .out_vld(out_vld), .out_left(out_left), .out_right(out_right)
  );

  function automatic longint sat24(input longint v);
    if (v > MAXV) return MAXV;
    if (v < MINV) return MINV;
    return v;
  endfunction

  task automatic check(input string tag, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // model of R3/R4/R5: output uses estimate before update
  task automatic send(input longint l, input longint r, input bit frz, input string tag);
    exp_t e;
    longint x[2];
    x[0] = l; x[1] = r;
    @(negedge clk);
    in_vld   = 1'b1;
    freeze   = frz;
    in_left  = l[W-1:0];
    in_right = r[W-1:0];
    e.l = sat24(x[0] - (acc_m[0] >>> SH));
    e.r = sat24(x[1] - (acc_m[1] >>> SH));
    e.tag = tag;
    if (!frz)
      for (int c = 0; c < 2; c++)
        acc_m[c] = acc_m[c] + (((x[c] <<< SH) - acc_m[c]) >>> SH);
    sb.push_back(e);
    n_sent++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_vld = 1'b0;
    end
  endtask

  // monitor: compare each result; while idle check that outputs hold (R8)
  always @(negedge clk) begin
    if (monitor_on) begin
      if (out_vld) begin
        if (sb.size() == 0) begin
          check("R2 unexpected out_vld", 1, 0);
        end else begin
          exp_t e;
          e = sb.pop_front();
          n_recv++;
          check({e.tag, " left"}, longint'(out_left), e.l);
          check({e.tag, " right"}, longint'(out_right), e.r);
        end
        last_l = out_left;
        last_r = out_right;
      end else begin
        check("R8 hold left", longint'(out_left), last_l);
        check("R8 hold right", longint'(out_right), last_r);
      end
    end
  end

  initial begin
    int cyc;
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_fail++;
        n_chk++;
        $display("FAIL watchdog actual=%0d expected<=150000", cyc);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
      end
    end
  end

  initial begin
    acc_m[0] = 0;
    acc_m[1] = 0;
    repeat (4) @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state at the ports
    check("R1 out_vld", longint'(out_vld), 0);
    check("R1 out_left", longint'(out_left), 0);
    check("R1 out_right", longint'(out_right), 0);
    monitor_on = 1'b1;

    // R1/R3: first sample passes through unchanged with cleared estimate
    send(123456, -654321, 1'b0, "R1 passthrough");
    idle(2);

    // R4 + R8: DC tracking with gaps between strobes
    for (int i = 0; i < 3000; i++) begin
      send(500000 + (i % 5) * 37, -20000, 1'b0, "R4 track");
      if (i % 7 == 0) idle(1);
    end
    idle(2);

    // R6: drive estimates to opposite extremes, then flip inputs
    for (int i = 0; i < 12000; i++)
      send(MINV, MAXV, 1'b0, "R6 ramp");
    for (int i = 0; i < 4; i++)
      send(MAXV, MINV, 1'b0, "R6 saturate");
    idle(1);

    // R5: frozen estimate, varied inputs including zero
    for (int i = 0; i < 600; i++)
      send((i % 3 == 0) ? 0 : i * 1013 - 200000, -(i * 517), 1'b1, "R5 frozen");
    idle(3);

    // R9: release freeze, tracking continues from held value
    for (int i = 0; i < 2000; i++)
      send(250000, 0, 1'b0, "R9 resume");
    idle(1);

    // R7: left constant, right swept; each channel follows its own history
    for (int i = 0; i < 1500; i++)
      send(-300000, (i * 4099) % 2000000 - 1000000, 1'b0, "R7 independent");
    idle(5);

    check("R2 result count", n_recv, n_sent);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule